// File: doc/BRIEF.md
# Serial Flash Command Parser

This block sits behind the pins of a serial NOR flash device and turns the serial command stream into one request per command. It oversamples SPI mode 0 traffic with the system clock: a rising serial clock edge while the active-low select is low shifts in one bit, most significant bit first. The first byte of each frame is the opcode. The parser derives from it how many address bytes follow, whether a dummy byte follows them, and how long the data phase may run.

Data bytes are handed out one at a time on a strobe while the frame is still open. When select rises, the frame is judged as a whole. A well-formed command issues a single request carrying its class, 24-bit address and data byte count. A malformed command leaves nothing behind.

A persistent write-enable latch guards every command that modifies the array or a register. It is set by a bare write-enable frame and is consumed by each modify command that is accepted.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: After reset `wel` is 0. A frame of exactly the 8 bits of opcode 06h sets `wel` when select rises. A write-enable frame with extra bits or bytes leaves `wel` unchanged.
- R2: A modify command (42h, 02h, A2h, 20h, D8h, C7h, 01h, E5h) issues a request only if `wel` was 1 when select rose. Otherwise it issues no request and `wel` stays 0.
- R3: An accepted modify command clears `wel` at the same time as its request.
- R4: `cmd_cls` encodes the opcode as follows: 3Bh=1, 4Bh=2, 42h=3, 02h=4, A2h=5, 20h=6, D8h=7, C7h=8, B9h=9, ABh=10, 01h=11, E5h=12.
- R5: Opcodes 3Bh, 4Bh, 42h, 02h, A2h, 20h, D8h and E5h take 3 address bytes, most significant byte first, which appear on `cmd_addr`. Commands without an address report 0. If select rises before the last address byte is complete, the frame is discarded.
- R6: After the address, 3Bh and 4Bh skip one dummy byte. The first `data_stb` carries the byte that follows the dummy byte.
- R7: Each data byte is presented on `data_byte` with a one-cycle `data_stb`, up to a per-command limit: 256 for 02h and A2h, 65 for 42h and 4Bh, 1 for 01h and E5h. Bytes beyond the limit are not strobed or counted. `cmd_len` is the number of bytes strobed. A data command with zero data bytes is discarded.
- R8: 3Bh has no data limit: every byte is strobed, and `cmd_len` saturates at 511.
- R9: If select rises when the bit count is not a whole number of bytes, the frame is discarded.
- R10: An unknown opcode produces no strobe and no request, and leaves `wel` unchanged.
- R11: A command with no data phase (C7h, B9h, ABh, 20h, D8h, 06h) that is followed by extra bytes is discarded.
- R12: An accepted command raises `cmd_valid` for exactly one clock cycle, 3 clock cycles after select rises at the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| wel | output | 1 | Write-enable latch |
| cmd_valid | output | 1 | One-cycle request pulse |
| cmd_cls | output | 4 | Command class of the request |
| cmd_addr | output | 24 | Address of the request |
| cmd_len | output | LEN_W | Data bytes strobed for the request |
| data_stb | output | 1 | One-cycle pulse for each completed data byte |
| data_byte | output | 8 | Value of the data byte |

## Verification
The hardest situations to reach are at the edges of the data-length limits and the write-enable latch. A page program must run past 256 bytes. A streaming read must run past 511 bytes before `cmd_len` saturates. The latch must be in the right state before a modify command and be observed after it. Directed frames cover these limits, truncated addresses, stray bits and trailing bytes. A seeded random sequence mixes write-enable frames with every opcode and with random lengths and stray bits, so that the latch meets modify commands in both states. A bench model predicts every request, strobe count, byte sum and latch value.

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front #(
  parameter int PAGE_MAX = 256,
  parameter int OTP_MAX  = 65,
  parameter int LEN_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             wel,
  output logic             cmd_valid,
  output logic [3:0]       cmd_cls,
  output logic [23:0]      cmd_addr,
  output logic [LEN_W-1:0] cmd_len,
  output logic             data_stb,
  output logic [7:0]       data_byte
);

  localparam logic [3:0] C_RDUAL = 4'd1, C_ROTP = 4'd2, C_POTP = 4'd3, C_PAGE = 4'd4,
                         C_PDUAL = 4'd5, C_ESUB = 4'd6, C_ESEC = 4'd7, C_EBULK = 4'd8,
                         C_DPD = 4'd9, C_REL = 4'd10, C_WSR = 4'd11, C_WLK = 4'd12,
                         C_WREN = 4'd13, C_BAD = 4'd15;
  localparam logic [LEN_W-1:0] LEN_SAT = '1;

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_DUM, PH_DATA, PH_END, PH_OVER, PH_IGN} phase_t;

  function automatic logic [3:0] decode(input logic [7:0] op);
    case (op)
      8'h3B: decode = C_RDUAL;
      8'h4B: decode = C_ROTP;
      8'h42: decode = C_POTP;
      8'h02: decode = C_PAGE;
      8'hA2: decode = C_PDUAL;
      8'h20: decode = C_ESUB;
      8'hD8: decode = C_ESEC;
      8'hC7: decode = C_EBULK;
      8'hB9: decode = C_DPD;
      8'hAB: decode = C_REL;
      8'h01: decode = C_WSR;
      8'hE5: decode = C_WLK;
      8'h06: decode = C_WREN;
      default: decode = C_BAD;
    endcase
  endfunction

  function automatic logic has_addr(input logic [3:0] c);
    has_addr = (c >= C_RDUAL && c <= C_ESEC) || c == C_WLK;
  endfunction

  function automatic logic has_dummy(input logic [3:0] c);
    has_dummy = (c == C_RDUAL) || (c == C_ROTP);
  endfunction

  function automatic logic has_data(input logic [3:0] c);
    has_data = (c >= C_RDUAL && c <= C_PDUAL) || c == C_WSR || c == C_WLK;
  endfunction

  function automatic logic is_mod(input logic [3:0] c);
    is_mod = (c >= C_POTP && c <= C_EBULK) || c == C_WSR || c == C_WLK;
  endfunction

  function automatic int limit(input logic [3:0] c);
    case (c)
      C_PAGE, C_PDUAL: limit = PAGE_MAX;
      C_ROTP, C_POTP:  limit = OTP_MAX;
      C_WSR, C_WLK:    limit = 1;
      default:         limit = 0;
    endcase
  endfunction

  logic [2:0] sclk_p, cs_p;
  logic [1:0] mosi_p;
  logic       sclk_rise, cs_s, cs_rise, mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], spi_sclk};
      cs_p   <= {cs_p[1:0], spi_cs_n};
      mosi_p <= {mosi_p[0], spi_mosi};
    end

  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign cs_s      = cs_p[1];
  assign cs_rise   = cs_p[1] & ~cs_p[2];
  assign mosi_s    = mosi_p[1];

  phase_t           phase;
  logic [6:0]       sh;
  logic [2:0]       bitcnt;
  logic [1:0]       acnt;
  logic [3:0]       cls;
  logic [23:0]      addr;
  logic [LEN_W-1:0] data_cnt;
  logic [7:0]       nxt;
  logic             frame_ok, room;

  assign nxt      = {sh, mosi_s};
  assign frame_ok = (bitcnt == 3'd0) &&
                    (phase == PH_END || (phase == PH_DATA && data_cnt != '0));
  assign room     = (limit(cls) == 0) || (int'(data_cnt) < limit(cls));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_OP;
      sh        <= '0;
      bitcnt    <= '0;
      acnt      <= '0;
      cls       <= C_BAD;
      addr      <= '0;
      data_cnt  <= '0;
      wel       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_cls   <= '0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      data_stb  <= 1'b0;
      data_byte <= '0;
    end else begin
      cmd_valid <= 1'b0;
      data_stb  <= 1'b0;
      if (cs_s) begin
        phase    <= PH_OP;
        bitcnt   <= '0;
        acnt     <= '0;
        addr     <= '0;
        data_cnt <= '0;
        if (cs_rise && frame_ok) begin
          if (cls == C_WREN)
            wel <= 1'b1;
          else if (!is_mod(cls) || wel) begin
            cmd_valid <= 1'b1;
            cmd_cls   <= cls;
            cmd_addr  <= addr;
            cmd_len   <= data_cnt;
            if (is_mod(cls)) wel <= 1'b0;
          end
        end
      end else if (sclk_rise) begin
        sh     <= nxt[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          case (phase)
            PH_OP: begin
              cls <= decode(nxt);
              if (decode(nxt) == C_BAD)        phase <= PH_IGN;
              else if (has_addr(decode(nxt)))  phase <= PH_ADDR;
              else if (has_data(decode(nxt)))  phase <= PH_DATA;
              else                             phase <= PH_END;
            end
            PH_ADDR: begin
              addr <= {addr[15:0], nxt};
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) begin
                if (has_dummy(cls))     phase <= PH_DUM;
                else if (has_data(cls)) phase <= PH_DATA;
                else                    phase <= PH_END;
              end
            end
            PH_DUM: phase <= PH_DATA;
            PH_DATA:
              if (room) begin
                data_stb  <= 1'b1;
                data_byte <= nxt;
                if (data_cnt != LEN_SAT) data_cnt <= data_cnt + LEN_W'(1);
              end
            PH_END:  phase <= PH_OVER;
            default: phase <= phase;
          endcase
        end
      end
    end

  p_wel_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  p_mod_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod(cmd_cls) |-> $past(wel));

  p_mod_clears_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_mod(cmd_cls) |-> !wel);

  p_stb_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |-> $past(!cs_s));

  p_page_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_cls == C_PAGE || cmd_cls == C_PDUAL) |->
      cmd_len != '0 && int'(cmd_len) <= PAGE_MAX);

  p_req_after_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise));

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

endmodule

// File: tb/spi_flash_cmd_front_test.sv
module spi_flash_cmd_front_test;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic wel, cmd_valid, data_stb;
  logic [3:0] cmd_cls;
  logic [23:0] cmd_addr;
  logic [8:0] cmd_len;
  logic [7:0] data_byte;

  spi_flash_cmd_front uut (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .wel(wel), .cmd_valid(cmd_valid), .cmd_cls(cmd_cls),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .data_stb(data_stb), .data_byte(data_byte));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int n_cmd, n_stb, stb_sum, first_byte, got_cls, got_addr, got_len;
  logic [7:0] fb [0:599];
  logic wel_m = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      n_cmd++; got_cls = int'(cmd_cls); got_addr = int'(cmd_addr); got_len = int'(cmd_len);
    end
    if (data_stb) begin
      if (n_stb == 0) first_byte = int'(data_byte);
      n_stb++; stb_sum += int'(data_byte);
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int b_cls(input logic [7:0] op);
    case (op)
      8'h3B: return 1;  8'h4B: return 2;  8'h42: return 3;  8'h02: return 4;
      8'hA2: return 5;  8'h20: return 6;  8'hD8: return 7;  8'hC7: return 8;
      8'hB9: return 9;  8'hAB: return 10; 8'h01: return 11; 8'hE5: return 12;
      8'h06: return 13; default: return 0;
    endcase
  endfunction
  function automatic int b_na(input int c);  return ((c >= 1 && c <= 7) || c == 12) ? 3 : 0; endfunction
  function automatic int b_dm(input int c);  return (c == 1 || c == 2) ? 1 : 0; endfunction
  function automatic bit b_dat(input int c); return (c >= 1 && c <= 5) || c == 11 || c == 12; endfunction
  function automatic bit b_mod(input int c); return (c >= 3 && c <= 8) || c == 11 || c == 12; endfunction
  function automatic int b_max(input int c);
    if (c == 4 || c == 5) return 256;
    if (c == 2 || c == 3) return 65;
    if (c == 11 || c == 12) return 1;
    return 100000;
  endfunction

  task automatic frame(input int nb, input int xbits);
    cs_n = 0; #60;
    for (int i = 0; i < nb; i++)
      for (int b = 7; b >= 0; b--) begin
        mosi = fb[i][b]; #30 sclk = 1; #30 sclk = 0;
      end
    for (int k = 0; k < xbits; k++) begin
      mosi = 1; #30 sclk = 1; #30 sclk = 0;
    end
    #60 cs_n = 1;
    repeat (20) @(posedge clk);
  endtask

  task automatic run(input logic [7:0] op, input int a, input int nd, input int xbits,
                     input int cut, input string tag);
    int c, na, dm, nb, exp_stb, exp_sum, exp_first, exp_len;
    bit acc;
    c = b_cls(op); na = b_na(c); dm = b_dm(c);
    fb[0] = op; nb = 1;
    for (int i = na - 1; i >= 0; i--) begin fb[nb] = 8'(a >> (8 * i)); nb++; end
    if (dm != 0) begin fb[nb] = 8'h5A; nb++; end
    exp_stb = 0; exp_sum = 0; exp_first = -1;
    for (int i = 0; i < nd; i++) begin
      fb[nb] = 8'($urandom);
      if (c != 0 && b_dat(c) && i < b_max(c)) begin
        if (exp_stb == 0) exp_first = int'(fb[nb]);
        exp_stb++; exp_sum += int'(fb[nb]);
      end
      nb++;
    end
    acc = (c != 0) && xbits == 0 && cut == 0 && (b_dat(c) ? nd > 0 : nd == 0);
    exp_len = exp_stb > 511 ? 511 : exp_stb;
    n_cmd = 0; n_stb = 0; stb_sum = 0; first_byte = -1;
    frame(nb - cut, xbits);
    if (c == 13) begin
      if (acc) wel_m = 1;
      acc = 0;
    end else if (acc && b_mod(c)) begin
      acc = wel_m;
      if (acc) wel_m = 0;
    end
    chk(n_cmd == int'(acc), tag, n_cmd, int'(acc));
    chk(n_stb == exp_stb, "R7 strobe count", n_stb, exp_stb);
    chk(stb_sum == exp_sum, "R7 strobe data", stb_sum, exp_sum);
    chk(wel == wel_m, "R1/R3 latch", int'(wel), int'(wel_m));
    if (dm != 0 && exp_stb > 0) chk(first_byte == exp_first, "R6 first after dummy", first_byte, exp_first);
    if (acc && n_cmd == 1) begin
      chk(got_cls == c, "R4 class", got_cls, c);
      chk(got_addr == (na != 0 ? (a & 24'hFFFFFF) : 0), "R5 address", got_addr, na != 0 ? (a & 24'hFFFFFF) : 0);
      chk(got_len == exp_len, "R7 length", got_len, exp_len);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] ops [0:13];
    ops = '{8'h06, 8'h3B, 8'h4B, 8'h42, 8'h02, 8'hA2, 8'h20, 8'hD8, 8'hC7, 8'hB9, 8'hAB, 8'h01, 8'hE5, 8'h99};
    void'($urandom(32'd7013));
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!wel && !cmd_valid && !data_stb, "R1 reset state", int'(wel), 0);

    run(8'hD8, 24'h123456, 0, 0, 0, "R2 erase without latch");
    run(8'h06, 0, 0, 0, 0, "R1 write enable");
    run(8'hD8, 24'hABCDEF, 0, 0, 0, "R3 erase consumes latch");
    run(8'h06, 0, 0, 3, 0, "R9 write enable stray bits");
    run(8'h06, 0, 1, 0, 0, "R11 write enable trailing byte");
    run(8'h06, 0, 0, 0, 0, "R1 write enable");
    run(8'h20, 24'h00F0F0, 0, 0, 1, "R5 truncated address");
    run(8'h99, 0, 4, 0, 0, "R10 unknown opcode");
    run(8'h02, 24'h010203, 257, 0, 0, "R7 page past limit");
    chk(n_cmd == 1, "R12 single cycle request", n_cmd, 1);
    run(8'h06, 0, 0, 0, 0, "R1 write enable");
    run(8'h02, 24'h0A0B0C, 0, 0, 0, "R7 page with no data");
    run(8'hC7, 0, 1, 0, 0, "R11 bulk erase trailing byte");
    run(8'h42, 24'h000010, 66, 0, 0, "R7 OTP program past limit");
    run(8'h4B, 24'h000020, 70, 0, 0, "R6 OTP read");
    run(8'h3B, 24'hFEDCBA, 515, 0, 0, "R8 streaming read");
    run(8'hB9, 0, 0, 0, 0, "R4 deep power-down");
    run(8'h02, 24'h111111, 3, 5, 0, "R9 program stray bits");

    for (int it = 0; it < 60; it++) begin
      int pick, nd, xb;
      pick = ($urandom_range(0, 9) < 3) ? 0 : int'($urandom_range(1, 13));
      nd = b_dat(b_cls(ops[pick])) ? int'($urandom_range(0, 10)) : (($urandom_range(0, 7) == 0) ? 1 : 0);
      xb = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 7)) : 0;
      run(ops[pick], int'($urandom), nd, xb, 0, "R2 random mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule